// File: doc/BRIEF.md
# Flash Write-Completion Status Poller

This engine sits on the host side of a parallel NOR flash. It runs a program, sector-erase or chip-erase operation from start to finish. It takes one request that carries the operation, the target address and the data byte. It drives the unlock and command writes onto a simple bus master that has one-cycle strobes. It then reads status from the flash until the operation has finished. The flash has no ready pin. Completion is read from the status bits of ordinary data reads, and each request picks one of two methods. Complement polling watches bit 7 of the status byte. Toggle detection watches bit 6 for two reads in a row that give the same value.

A programmable limit sets the largest number of status reads for one operation. If the limit is used up before completion is seen, the operation ends with a timeout. In toggle mode, a last read compares the whole byte with the expected contents. The engine gives one pulse to report the end of the operation, and a flag pulse beside it gives the kind of failure.

Requests use valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the engine is idle, so the requester must hold `req_valid` and all request fields steady until that edge. The engine has no output stream. Its results are the status pulses.

Top module: `flash_poll_engine`

## Requirements
- R1: `req_ready` is high only when the engine is idle. It goes low in the cycle after a request is accepted and stays low until the cycle in which `done` pulses. A request is accepted only on an edge where `req_valid` and `req_ready` are both high.
- R2: A program request (op 0) gives four write strobes on consecutive cycles, beginning the cycle after acceptance, in this order of (address, data): (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), (request address, request data).
- R3: An erase request gives six consecutive write strobes: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55), and then a last write. For a sector erase (op 1) the last write is (request address, 0x30). For a chip erase (op 2) it is (0x5555, 0x10).
- R4: No status read is issued until the last write strobe of the sequence is finished. The first read strobe comes in the cycle right after that write, and a read strobe is never high together with a write strobe. Every read uses the request address. Read data is sampled one cycle after its strobe.
- R5: In complement mode (`req_mode`=0), a program operation is complete when bit 7 of the read data equals bit 7 of the programmed byte.
- R6: In complement mode, an erase operation is complete when bit 7 of the read data is 1.
- R7: In toggle mode (`req_mode`=1), the operation is complete when two reads in a row return the same bit 6.
- R8: After completion in toggle mode, the engine makes one more read. If that byte differs from the expected contents, `err_verify` pulses together with `done`. The expected contents are the data byte for a program and 0xFF for an erase.
- R9: If `poll_limit` status reads have been made without completion, the operation ends with `err_timeout` pulsing together with `done`. A limit of 0 acts as 1. A completion seen on the last allowed read is a success.
- R10: `done` is high for exactly one cycle per operation, in the cycle after the last read data is sampled. `err_timeout` and `err_verify` are high only together with `done`, and never both at once.
- R11: A request with op 3 is consumed with no effect: no strobe, no `done` pulse, and `req_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 no operation |
| req_mode | input | 1 | 0 bit-7 complement polling, 1 bit-6 toggle detection |
| req_addr | input | ADDR_W | Target address |
| req_data | input | 8 | Byte to program |
| poll_limit | input | CNT_W | Largest number of status reads |
| bus_we | output | 1 | One-cycle write strobe |
| bus_re | output | 1 | One-cycle read strobe |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid one cycle after `bus_re` |
| done | output | 1 | Operation finished (pulse) |
| err_timeout | output | 1 | Read limit used up (pulse with `done`) |
| err_verify | output | 1 | Toggle-mode final byte mismatch (pulse with `done`) |

## Verification
The assertions assume three things about the inputs. The flash returns read data exactly one cycle after each read strobe. `poll_limit` and the request fields do not change while `req_valid` waits for acceptance. Reset is applied before the first request. The bench meets these conditions in the following way:
- It drives a flash model that registers its answer on the read-strobe edge.
- It sets each request completely at a falling edge, before raising `req_valid`.
- It drops `req_valid` right after acceptance.
- It changes the limit only between operations.

The model makes bit 6 toggle on every busy read. It begins from a value chosen so that the last busy read always differs from the final data. With that, the number of reads for toggle mode is fixed in advance.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_NONE = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WR   = 3'd1,
    ST_RD   = 3'd2,
    ST_CHK  = 3'd3,
    ST_VRD  = 3'd4,
    ST_VCHK = 3'd5
  } st_e;

  localparam logic [BYTE_W-1:0] K_KEY1  = 8'hAA;
  localparam logic [BYTE_W-1:0] K_KEY2  = 8'h55;
  localparam logic [BYTE_W-1:0] K_PROG  = 8'hA0;
  localparam logic [BYTE_W-1:0] K_ERASE = 8'h80;
  localparam logic [BYTE_W-1:0] K_SECT  = 8'h30;
  localparam logic [BYTE_W-1:0] K_CHIP  = 8'h10;
  localparam logic [BYTE_W-1:0] K_BLANK = 8'hFF;

  localparam int STEP_W    = 3;
  localparam int LAST_PROG = 3;
  localparam int LAST_ERAS = 5;
endpackage

// File: rtl/fpe_cmd_seq.sv
module fpe_cmd_seq
  import fpe_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter logic [ADDR_W-1:0] KEY_A1 = ADDR_W'('h5555),
  parameter logic [ADDR_W-1:0] KEY_A2 = ADDR_W'('h2AAA)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  op_e               op,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [BYTE_W-1:0] tgt_data,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BYTE_W-1:0] cmd_data,
  output logic              is_last
);
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] last_idx;
  logic              prog;

  assign prog     = (op == OP_PROG);
  assign last_idx = prog ? STEP_W'(LAST_PROG) : STEP_W'(LAST_ERAS);
  assign is_last  = (step_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   step_q <= '0;
    else if (clr) step_q <= '0;
    else if (adv) step_q <= is_last ? '0 : step_q + 1'b1;
  end

  always_comb begin
    cmd_addr = KEY_A1;
    cmd_data = K_KEY1;
    case (step_q)
      3'd0: begin cmd_addr = KEY_A1; cmd_data = K_KEY1; end
      3'd1: begin cmd_addr = KEY_A2; cmd_data = K_KEY2; end
      3'd2: begin cmd_addr = KEY_A1; cmd_data = prog ? K_PROG : K_ERASE; end
      3'd3: begin
        cmd_addr = prog ? tgt_addr : KEY_A1;
        cmd_data = prog ? tgt_data : K_KEY1;
      end
      3'd4: begin cmd_addr = KEY_A2; cmd_data = K_KEY2; end
      default: begin
        cmd_addr = (op == OP_SECT) ? tgt_addr : KEY_A1;
        cmd_data = (op == OP_SECT) ? K_SECT : K_CHIP;
      end
    endcase
  end

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= STEP_W'(LAST_ERAS)) else $error("step out of range"); // R3
endmodule

// File: rtl/fpe_status_eval.sv
module fpe_status_eval
  import fpe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sample,
  input  logic              mode_toggle,
  input  logic [BYTE_W-1:0] exp_byte,
  input  logic [BYTE_W-1:0] rdata,
  output logic              complete,
  output logic              byte_ok
);
  logic have_q;
  logic prev6_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      prev6_q <= 1'b0;
    end else if (clr) begin
      have_q  <= 1'b0;
    end else if (sample) begin
      have_q  <= 1'b1;
      prev6_q <= rdata[6];
    end
  end

  assign complete = mode_toggle ? (have_q && (rdata[6] == prev6_q))
                                : (rdata[7] == exp_byte[7]);
  assign byte_ok  = (rdata == exp_byte);
endmodule

// File: rtl/fpe_poll_timer.sv
module fpe_poll_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic             last_try
);
  localparam int EXT_W = CNT_W + 1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign last_try = ({1'b0, cnt_q} + EXT_W'(1)) >= {1'b0, limit};

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (cnt_q != {CNT_W{1'b1}})) else $error("poll counter wrap"); // R9
endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
  import fpe_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_mode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic [CNT_W-1:0]  poll_limit,
  output logic              bus_we,
  output logic              bus_re,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  output logic              done,
  output logic              err_timeout,
  output logic              err_verify
);
  st_e               st_q, st_d;
  op_e               op_q;
  logic              mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0] exp_byte;
  logic              accept;
  logic              seq_last, complete, byte_ok, last_try, tmr_inc;
  logic [ADDR_W-1:0] cmd_addr;
  logic [BYTE_W-1:0] cmd_data;
  logic              done_d, tmo_d, vfy_d;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign exp_byte  = (op_q == OP_PROG) ? data_q : K_BLANK;

  fpe_cmd_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .clr(accept), .adv(st_q == ST_WR),
    .op(op_q), .tgt_addr(addr_q), .tgt_data(data_q),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .is_last(seq_last)
  );

  fpe_status_eval eval_i (
    .clk(clk), .rst_n(rst_n), .clr(accept), .sample(st_q == ST_CHK),
    .mode_toggle(mode_q), .exp_byte(exp_byte), .rdata(bus_rdata),
    .complete(complete), .byte_ok(byte_ok)
  );

  assign tmr_inc = (st_q == ST_CHK) && !complete && !last_try;

  fpe_poll_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .clr(accept), .inc(tmr_inc),
    .limit(poll_limit), .last_try(last_try)
  );

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    tmo_d  = 1'b0;
    vfy_d  = 1'b0;
    case (st_q)
      ST_IDLE: if (accept && (op_e'(req_op) != OP_NONE)) st_d = ST_WR;
      ST_WR:   if (seq_last) st_d = ST_RD;
      ST_RD:   st_d = ST_CHK;
      ST_CHK: begin
        if (complete) begin
          if (mode_q) st_d = ST_VRD;
          else begin st_d = ST_IDLE; done_d = 1'b1; end
        end else if (last_try) begin
          st_d = ST_IDLE; done_d = 1'b1; tmo_d = 1'b1;
        end else begin
          st_d = ST_RD;
        end
      end
      ST_VRD:  st_d = ST_VCHK;
      ST_VCHK: begin st_d = ST_IDLE; done_d = 1'b1; vfy_d = !byte_ok; end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      op_q        <= OP_PROG;
      mode_q      <= 1'b0;
      addr_q      <= '0;
      data_q      <= '0;
      done        <= 1'b0;
      err_timeout <= 1'b0;
      err_verify  <= 1'b0;
    end else begin
      st_q        <= st_d;
      done        <= done_d;
      err_timeout <= tmo_d;
      err_verify  <= vfy_d;
      if (accept) begin
        op_q   <= op_e'(req_op);
        mode_q <= req_mode;
        addr_q <= req_addr;
        data_q <= req_data;
      end
    end
  end

  assign bus_we    = (st_q == ST_WR);
  assign bus_re    = (st_q == ST_RD) || (st_q == ST_VRD);
  assign bus_addr  = bus_we ? cmd_addr : addr_q;
  assign bus_wdata = bus_we ? cmd_data : '0;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re)) else $error("read and write together"); // R4
  AST_READ_AFTER_LAST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && $past(bus_we)) |-> $past(seq_last)) else $error("early poll"); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_timeout || err_verify) |-> done) else $error("flag without done"); // R10
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_timeout && err_verify)) else $error("both flags"); // R10
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(bus_we || bus_re)) else $error("strobe while idle"); // R11
endmodule

// File: tb/flash_poll_engine_tb.sv
module flash_poll_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic          req_mode = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = 8'h00;
  logic [CW-1:0] poll_limit = 16'd10;
  logic          bus_we, bus_re;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic [7:0]    bus_rdata = 8'h00;
  logic          done, err_timeout, err_verify;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_poll_engine #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_mode(req_mode), .req_addr(req_addr), .req_data(req_data),
    .poll_limit(poll_limit), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done),
    .err_timeout(err_timeout), .err_verify(err_verify)
  );

  // flash model: busy for m_busy reads after the last write
  int            m_busy = 0;
  logic [7:0]    m_final = 8'h00;
  logic          m_b7 = 1'b0;
  logic          m_tog0 = 1'b0;
  int            busy_left = 0;
  logic          tog = 1'b0;
  int            wcnt = 0;
  int            rcnt = 0;
  logic [AW-1:0] wl_a [64];
  logic [7:0]    wl_d [64];
  logic [AW-1:0] rd_a_last = '0;

  always @(posedge clk) begin
    if (bus_we) begin
      wl_a[wcnt & 63] <= bus_addr;
      wl_d[wcnt & 63] <= bus_wdata;
      wcnt <= wcnt + 1;
      busy_left <= m_busy;
      tog <= m_tog0;
    end
    if (bus_re) begin
      rcnt <= rcnt + 1;
      rd_a_last <= bus_addr;
      if (busy_left > 0) begin
        bus_rdata <= {m_b7, tog, 6'b0};
        tog <= ~tog;
        busy_left <= busy_left - 1;
      end else begin
        bus_rdata <= m_final;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic exp_write(input int op, input int i, input logic [AW-1:0] a,
                           input logic [7:0] d, output logic [AW-1:0] ea,
                           output logic [7:0] ed);
    logic [AW-1:0] k1, k2;
    k1 = AW'('h5555); k2 = AW'('h2AAA);
    case (i)
      0: begin ea = k1; ed = 8'hAA; end
      1: begin ea = k2; ed = 8'h55; end
      2: begin ea = k1; ed = (op == 0) ? 8'hA0 : 8'h80; end
      3: begin ea = (op == 0) ? a : k1; ed = (op == 0) ? d : 8'hAA; end
      4: begin ea = k2; ed = 8'h55; end
      default: begin ea = (op == 1) ? a : k1; ed = (op == 1) ? 8'h30 : 8'h10; end
    endcase
  endtask

  // generic operation runner with full checking
  task automatic run_op(input string req, input int op, input bit mode,
                        input logic [AW-1:0] a, input logic [7:0] d,
                        input int limit, input int busy, input logic [7:0] fin);
    int nw, need, leff, exp_r, lat, w0, r0;
    bit exp_tmo, exp_vfy;
    logic [AW-1:0] ea;
    logic [7:0] ed;
    nw   = (op == 0) ? 4 : 6;
    leff = (limit == 0) ? 1 : limit;
    need = mode ? busy + 2 : busy + 1;
    exp_tmo = need > leff;
    exp_r   = exp_tmo ? leff : (mode ? need + 1 : need);
    exp_vfy = !exp_tmo && mode && (fin != ((op == 0) ? d : 8'hFF));
    @(negedge clk);
    m_busy  = busy;
    m_final = fin;
    m_b7    = (op == 0) ? ~d[7] : 1'b0;
    m_tog0  = ~fin[6] ^ (busy > 0 ? 1'((busy - 1) & 1) : 1'b0);
    poll_limit = CW'(limit);
    req_op = 2'(op); req_mode = mode; req_addr = a; req_data = d;
    w0 = wcnt; r0 = rcnt;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    check(req_ready == 1'b0, "R1", {req, " ready low when busy"}, req_ready, 0);
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    check(lat == nw + 2 * exp_r + 1, req, "done latency", lat, nw + 2 * exp_r + 1);
    check(wcnt - w0 == nw, (op == 0) ? "R2" : "R3", "write count", wcnt - w0, nw);
    for (int i = 0; i < nw; i++) begin
      exp_write(op, i, a, d, ea, ed);
      check(wl_a[(w0 + i) & 63] == ea && wl_d[(w0 + i) & 63] == ed,
            (op == 0) ? "R2" : "R3", $sformatf("write %0d addr/data", i),
            int'({wl_a[(w0 + i) & 63], wl_d[(w0 + i) & 63]}), int'({ea, ed}));
    end
    check(rcnt - r0 == exp_r, req, "read count", rcnt - r0, exp_r);
    check(rd_a_last == a, "R4", "read address", int'(rd_a_last), int'(a));
    check(err_timeout == exp_tmo, "R9", "timeout flag", err_timeout, exp_tmo);
    check(err_verify == exp_vfy, "R8", "verify flag", err_verify, exp_vfy);
    @(negedge clk);
    check(done == 1'b0 && err_timeout == 1'b0 && err_verify == 1'b0, "R10",
          "pulse one cycle", int'({done, err_timeout, err_verify}), 0);
    check(req_ready == 1'b1, "R1", "ready after done", req_ready, 1);
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1 && bus_we == 1'b0 && bus_re == 1'b0 && done == 1'b0,
          "R1", "reset state", int'({req_ready, bus_we, bus_re, done}), 8);
  endtask

  task automatic t_prog_dq7;    run_op("R5", 0, 1'b0, 18'h01234, 8'h3C, 20, 3, 8'h3C); endtask
  task automatic t_prog_dq7_hi; run_op("R5", 0, 1'b0, 18'h2FFFF, 8'hC5, 20, 0, 8'hC5); endtask
  task automatic t_sect_dq7;    run_op("R6", 1, 1'b0, 18'h30000, 8'h00, 20, 5, 8'hFF); endtask
  task automatic t_chip_dq6;    run_op("R7", 2, 1'b1, 18'h00040, 8'h00, 20, 4, 8'hFF); endtask
  task automatic t_prog_dq6;    run_op("R7", 0, 1'b1, 18'h00777, 8'h81, 20, 0, 8'h81); endtask
  task automatic t_prog_dq6_odd; run_op("R7", 0, 1'b1, 18'h10001, 8'h42, 20, 5, 8'h42); endtask
  task automatic t_verify_bad;  run_op("R8", 1, 1'b1, 18'h20000, 8'h00, 20, 2, 8'hFB); endtask
  task automatic t_limit_exact; run_op("R9", 0, 1'b0, 18'h00100, 8'h11, 4, 3, 8'h11); endtask
  task automatic t_limit_short; run_op("R9", 0, 1'b0, 18'h00100, 8'h11, 3, 3, 8'h11); endtask
  task automatic t_limit_zero;  run_op("R9", 1, 1'b0, 18'h00200, 8'h00, 0, 2, 8'hFF); endtask
  task automatic t_dq6_timeout; run_op("R9", 2, 1'b1, 18'h00300, 8'h00, 6, 50, 8'hFF); endtask

  task automatic t_op_none;
    int w0, r0;
    bit seen_done;
    seen_done = 1'b0;
    @(negedge clk);
    w0 = wcnt; r0 = rcnt;
    req_op = 2'd3; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) seen_done = 1'b1;
    end
    check(wcnt == w0 && rcnt == r0, "R11", "no strobes for op 3",
          wcnt - w0 + rcnt - r0, 0);
    check(!seen_done, "R11", "no done for op 3", seen_done, 0);
    check(req_ready == 1'b1, "R11", "ready stays high", req_ready, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_prog_dq7();
    t_prog_dq7_hi();
    t_sect_dq7();
    t_chip_dq6();
    t_prog_dq6();
    t_prog_dq6_odd();
    t_verify_bad();
    t_limit_exact();
    t_limit_short();
    t_limit_zero();
    t_dq6_timeout();
    t_op_none();
    t_prog_dq7();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule